// File: doc/BRIEF.md
# SD/MMC Host Interrupt Flag and Mask Unit

This block gathers event indications from an SD/MMC host core and turns them into one interrupt request toward the CPU. Four sources are one-cycle pulses: the card's SDIO interrupt, the end of a command response, the end of card programming, and the end of a data transfer. Each pulse sets a flag that stays set until software clears it. Two sources are FIFO threshold levels: the transmit FIFO asking for data and the receive FIFO holding data to be read. These are shown live and never latched.

A 16-bit mask register decides which flags may drive the interrupt line. A mask bit of one blocks its source and a zero lets it through. The mask resets to all ones, so nothing interrupts until software opens a source. A small register port selects the flag word or the mask word for reading. It writes the mask directly. On the flag word a write clears every flag whose data bit is one. Masked flags can still be read, so software may poll without taking the interrupt.

Top module: `sdhost_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on an event input sets its flag from the following clock edge onward. The flag positions are: bit 7 SDIO, bit 2 command response end, bit 1 programming done, bit 0 data transfer done. The flag stays set until it is cleared.
- R2: After reset the flag word (reg_addr=0) reads 0x0000, the mask word (reg_addr=1) reads 0xFFFF, and irq_o is 0.
- R3: A mask bit of 1 keeps its flag from raising irq_o and a mask bit of 0 lets it through. irq_o is high in the cycle after some flag is set while its mask bit is 0.
- R4: A write to reg_addr=0 clears every sticky flag whose wdata bit is 1 and leaves flags under 0 bits unchanged. Writing 0xFFFF clears all sticky flags.
- R5: Flags read as set in the flag word whether or not they are masked.
- R6: Flag bit 6 follows lvl_tx_req and flag bit 5 follows lvl_rx_req in the same cycle. A write-one-to-clear on these bits has no effect.
- R7: When an event pulse and a clearing write hit the same flag in the same cycle, the flag is set afterwards.
- R8: Flag bits 15:8, 4 and 3 always read 0. The mask word reads back the full 16-bit value last written to reg_addr=1.
- R9: irq_o falls in the cycle after no unmasked flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_sdio | input | 1 | SDIO card interrupt pulse |
| ev_cmd_end | input | 1 | Command response finished pulse |
| ev_prog_done | input | 1 | Card programming finished pulse |
| ev_xfer_done | input | 1 | Data transfer finished pulse |
| lvl_tx_req | input | 1 | Transmit FIFO wants data (level) |
| lvl_rx_req | input | 1 | Receive FIFO has data (level) |
| reg_addr | input | 1 | Word select: 0 flags, 1 mask |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case is a clearing write and a new event landing on the same flag in the same cycle. The stimulus forces it by raising the event pulse and the write strobe before the same clock edge. The bench then checks that the flag reads set and that the interrupt follows one cycle later. A second awkward case is a write-one-to-clear aimed at a FIFO request bit while its level is held high. The bench reads the flag word right after that write to show the bit survived, then drops the level and sees the bit go to zero.

// File: rtl/sdhost_irq_pkg.sv
// Package: shared constants for the SD/MMC interrupt flag and mask unit.
// Bit positions are fixed because software decodes them.
package sdhost_irq_pkg;
    parameter int FLAG_W      = 16;
    parameter int POS_XFER    = 0;
    parameter int POS_PROG    = 1;
    parameter int POS_CMD     = 2;
    parameter int POS_RX_REQ  = 5;
    parameter int POS_TX_REQ  = 6;
    parameter int POS_SDIO    = 7;

    // Bits that latch on a pulse and hold until cleared.
    localparam logic [FLAG_W-1:0] STICKY_BITS =
        FLAG_W'((1 << POS_XFER) | (1 << POS_PROG) | (1 << POS_CMD) | (1 << POS_SDIO));
    // Bits that mirror a live level.
    localparam logic [FLAG_W-1:0] LEVEL_BITS =
        FLAG_W'((1 << POS_RX_REQ) | (1 << POS_TX_REQ));
    // Reset value of the mask: every source blocked.
    localparam logic [FLAG_W-1:0] MASK_RESET = {FLAG_W{1'b1}};

    typedef enum logic { SEL_FLAGS = 1'b0, SEL_MASK = 1'b1 } reg_sel_e;
endpackage

// File: rtl/sdhost_irq_flag_bank.sv
// Flag bank: holds the sticky event flags and shows the level sources.
// Assumes set_vec pulses come from the core and clr_vec from a register
// write. On the same bit in the same cycle, set takes priority over clear.
module sdhost_irq_flag_bank #(
    parameter int                W      = 16,
    parameter logic [W-1:0]      STICKY = '0,
    parameter logic [W-1:0]      LEVEL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic [W-1:0] lvl_vec,
    output logic [W-1:0] flags
);
    logic [W-1:0] held_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit latch: set dominates clear; non-sticky bits stay zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held_q[i] <= 1'b0;
            else if (STICKY[i])
                held_q[i] <= set_vec[i] | (held_q[i] & ~clr_vec[i]);
            else
                held_q[i] <= 1'b0;
        end

        // Visible flag: level sources are shown live, others come from the latch.
        assign flags[i] = LEVEL[i] ? lvl_vec[i] : held_q[i];

        if (STICKY[i]) begin : g_chk
            assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $past(set_vec[i]) |-> flags[i]);
            assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(flags[i]) && !$past(clr_vec[i])) |-> flags[i]);
            assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(clr_vec[i]) && !$past(set_vec[i])) |-> !flags[i]);
        end
    end
endmodule

// File: rtl/sdhost_irq_mask_reg.sv
// Mask register: a one blocks its source. Resets to MASK_RESET.
// Assumes a single write strobe with full-width data.
module sdhost_irq_mask_reg #(
    parameter int           W     = 16,
    parameter logic [W-1:0] RST_V = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    // Mask storage with synchronous reset to all-blocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= RST_V;
        else if (we)
            mask <= wdata;
    end

    assert_mask_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask == RST_V));
    assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we)) |-> (mask == $past(wdata)));
endmodule

// File: rtl/sdhost_irq_line.sv
// Interrupt line: OR of unmasked flags, registered once.
// Assumes flags and mask are both valid in the same cycle.
module sdhost_irq_line #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic         irq_o
);
    logic [W-1:0] live;
    logic         any_live;

    // Reduce the enabled flags to one request.
    always_comb begin
        live     = flags & ~mask;
        any_live = |live;
    end

    // Register the request toward the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= any_live;
    end

    assert_irq_needs_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_o) |-> ($past(flags & ~mask) != '0));
    assert_irq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(flags & ~mask) == '0)) |-> !irq_o);
endmodule

// File: rtl/sdhost_irq_reg_port.sv
// Register port: decodes the word select and write strobe into the
// clear vector and mask write enable, and muxes the read data.
// Assumes the read is combinational on reg_addr.
module sdhost_irq_reg_port
    import sdhost_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         reg_addr,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic [W-1:0] clr_vec,
    output logic         mask_we,
    output logic [W-1:0] reg_rdata
);
    reg_sel_e sel;

    // Decode the access into its effect on flags or mask.
    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        clr_vec   = (reg_wr && sel == SEL_FLAGS) ? reg_wdata : '0;
        mask_we   = reg_wr && (sel == SEL_MASK);
        reg_rdata = (sel == SEL_MASK) ? mask : flags;
    end
endmodule

// File: rtl/sdhost_irq_ctrl.sv
// Top: SD/MMC host interrupt flag and mask unit.
// Collects four event pulses and two FIFO levels into a 16-bit flag word,
// filters with a 16-bit mask (1 = blocked), drives one registered irq.
// Assumes synchronous active-low reset and single-cycle event pulses.
module sdhost_irq_ctrl
    import sdhost_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_sdio,
    input  logic              ev_cmd_end,
    input  logic              ev_prog_done,
    input  logic              ev_xfer_done,
    input  logic              lvl_tx_req,
    input  logic              lvl_rx_req,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int W = FLAG_W;

    logic [W-1:0] set_vec;
    logic [W-1:0] lvl_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] flags;
    logic [W-1:0] mask;
    logic         mask_we;

    // Place the event and level inputs at their fixed bit positions.
    always_comb begin
        set_vec             = '0;
        set_vec[POS_SDIO]   = ev_sdio;
        set_vec[POS_CMD]    = ev_cmd_end;
        set_vec[POS_PROG]   = ev_prog_done;
        set_vec[POS_XFER]   = ev_xfer_done;
        lvl_vec             = '0;
        lvl_vec[POS_TX_REQ] = lvl_tx_req;
        lvl_vec[POS_RX_REQ] = lvl_rx_req;
    end

    sdhost_irq_reg_port #(.W(W)) u_port (
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .flags    (flags),
        .mask     (mask),
        .clr_vec  (clr_vec),
        .mask_we  (mask_we),
        .reg_rdata(reg_rdata)
    );

    sdhost_irq_flag_bank #(.W(W), .STICKY(STICKY_BITS), .LEVEL(LEVEL_BITS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .lvl_vec(lvl_vec),
        .flags  (flags)
    );

    sdhost_irq_mask_reg #(.W(W), .RST_V(MASK_RESET)) u_mask (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mask_we),
        .wdata(reg_wdata),
        .mask (mask)
    );

    sdhost_irq_line #(.W(W)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .flags(flags),
        .mask (mask),
        .irq_o(irq_o)
    );

    assert_level_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_tx_req && reg_wr && !reg_addr) |-> flags[POS_TX_REQ]);
endmodule

// File: tb/tb_sdhost_irq_ctrl.sv
`timescale 1ns/100ps
module tb_sdhost_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_sdio = 1'b0, ev_cmd_end = 1'b0, ev_prog_done = 1'b0, ev_xfer_done = 1'b0;
    logic        lvl_tx_req = 1'b0, lvl_rx_req = 1'b0;
    logic        reg_addr = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    sdhost_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .ev_sdio(ev_sdio), .ev_cmd_end(ev_cmd_end),
        .ev_prog_done(ev_prog_done), .ev_xfer_done(ev_xfer_done),
        .lvl_tx_req(lvl_tx_req), .lvl_rx_req(lvl_rx_req),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // Monitor: pops expected items and compares at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {15'd0, irq_o} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic expect_rd(input logic a, input logic [15:0] e, input string tag);
        reg_addr = a;
        sb_q.push_back('{1'b0, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        sb_q.push_back('{1'b1, {15'd0, e}, tag});
        @(negedge clk); #1;
    endtask

    task automatic write_reg(input logic a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic s, input logic c, input logic p, input logic x);
        ev_sdio = s; ev_cmd_end = c; ev_prog_done = p; ev_xfer_done = x;
        step();
        ev_sdio = 0; ev_cmd_end = 0; ev_prog_done = 0; ev_xfer_done = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        expect_rd(0, 16'h0000, "R2 flags after reset");
        expect_rd(1, 16'hFFFF, "R2 mask after reset");
        expect_irq(0, "R2 irq after reset");

        pulse(1, 0, 0, 0);
        expect_rd(0, 16'h0080, "R1 SDIO sets bit 7 / R5 visible while masked");
        expect_irq(0, "R3 masked flag gives no irq");
        pulse(0, 1, 0, 0);
        pulse(0, 0, 1, 0);
        pulse(0, 0, 0, 1);
        expect_rd(0, 16'h0087, "R1 cmd/prog/xfer on bits 2,1,0 and held");

        write_reg(0, 16'h0001);
        expect_rd(0, 16'h0086, "R4 W1C bit 0");
        write_reg(0, 16'h0000);
        expect_rd(0, 16'h0086, "R4 zero write keeps flags");

        write_reg(1, 16'hFFFB);
        expect_irq(0, "R3 irq not before the registered cycle");
        expect_rd(1, 16'hFFFB, "R8 mask readback");
        step();
        expect_irq(1, "R3 unmasked bit 2 raises irq");

        write_reg(0, 16'h0004);
        expect_rd(0, 16'h0082, "R4 bit 2 cleared");
        step();
        expect_irq(0, "R9 irq falls after cause gone");

        ev_cmd_end = 1'b1;
        write_reg(0, 16'h0004);
        ev_cmd_end = 1'b0;
        expect_rd(0, 16'h0086, "R7 set wins over clear");
        step();
        expect_irq(1, "R7 irq follows the winning set");

        write_reg(0, 16'hFFFF);
        expect_rd(0, 16'h0000, "R4 0xFFFF clears all sticky");
        step();
        expect_irq(0, "R9 irq falls after clear-all");

        lvl_tx_req = 1'b1;
        expect_rd(0, 16'h0040, "R6 tx level shown on bit 6");
        write_reg(0, 16'h0040);
        expect_rd(0, 16'h0040, "R6 W1C on tx level bit ignored");
        expect_irq(0, "R3 tx level masked");
        lvl_tx_req = 1'b0;
        expect_rd(0, 16'h0000, "R6 tx bit follows level low");
        lvl_rx_req = 1'b1;
        expect_rd(0, 16'h0020, "R6 rx level shown on bit 5");
        write_reg(1, 16'hFFDF);
        step();
        expect_irq(1, "R3 unmasked rx level raises irq");
        lvl_rx_req = 1'b0;
        step();
        expect_irq(0, "R9 irq drops with rx level");

        write_reg(1, 16'hA5A5);
        expect_rd(1, 16'hA5A5, "R8 mask full-width readback");
        write_reg(1, 16'h0000);
        lvl_tx_req = 1'b1; lvl_rx_req = 1'b1;
        pulse(1, 1, 1, 1);
        expect_rd(0, 16'h00E7, "R8 unused bits zero with all sources active");
        step();
        expect_irq(1, "R3 all sources enabled");
        lvl_tx_req = 1'b0; lvl_rx_req = 1'b0;
        write_reg(0, 16'hFFFF);
        expect_rd(0, 16'h0000, "R8 unused bits zero after clear");
        step();

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule